// File: doc/BRIEF.md
# Dual Timer/Counter Unit

This block holds two independent counting channels. Each channel has a low byte and a high byte. A shared mode byte sets, for each channel, a gate enable, a source select and a two-bit counting structure. A control byte holds a run bit and a sticky overflow flag for each channel. Each channel counts either a one-cycle machine tick pulse, supplied by the surrounding chip at one twelfth of the oscillator rate, or falling edges on its external count pin. The count pin is sampled only on ticks.

The gate input of a channel allows counting only while that input is high. With the count cleared, this measures the width of a high pulse in machine cycles. Software reads and writes the registers through a small byte port with a combinational read path. An acknowledge input per channel clears its flag when the interrupt is serviced. Four counting structures are offered: a 13-bit counter with a 5-bit prescaler, a full 16-bit counter, an 8-bit counter with auto-reload, and a split arrangement that turns channel 0 into two 8-bit timers.

Top module: `twin_timer`

## Requirements
- R1: After reset, every register reads zero and both flags are low.
- R2: In tick mode (source select 0), an enabled channel advances by exactly one on each cycle where `tick` is 1. It never advances on a cycle where `tick` is 0.
- R3: Mode 01 counts {high,low} as 16 bits. Moving from 0xFFFF to 0x0000 sets the flag of that channel.
- R4: A set flag stays set and counting goes on. Writing the control byte loads both flags from bits 3:2.
- R5: A pulse on `ack[c]` clears flag c and no other flag. An overflow in the same cycle wins over the acknowledge.
- R6: Mode 00 counts {high byte, low[4:0]} as 13 bits and leaves low[7:5] unchanged. The flag is set when this 13-bit value moves from all ones to zero.
- R7: In mode 10 only the low byte counts. An increment from 0xFF sets the flag and loads the low byte from the high byte in the same cycle.
- R8: A channel advances only when its run bit is 1 and either its gate bit is 0 or `gate_pin` of that channel is 1.
- R9: In edge mode (source select 1), the channel advances on a tick when the previous tick's sample of `cnt_pin` was 1 and the current level is 0.
- R10: A change on `cnt_pin` that starts and ends between two ticks is not counted.
- R11: Channel 0 in mode 11 behaves as two 8-bit timers. Its low byte uses the controls of channel 0 and sets flag 0. Its high byte counts ticks while run bit 1 is set and sets flag 1 when it wraps.
- R12: Channel 1 in mode 11 holds both of its bytes.
- R13: A register write to a count byte wins over an increment in the same cycle. A write of the control byte wins over a flag set in the same cycle.
- R14: The register map is as follows. Address 0 is the mode byte: channel 0 in bits 3:0, channel 1 in bits 7:4, each nibble laid out as {gate, source select, mode[1:0]}. Address 1 is the control byte {0000, flag1, flag0, run1, run0}. Addresses 2 and 3 are the low and high bytes of channel 0. Addresses 4 and 5 are the low and high bytes of channel 1. Addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Machine-cycle tick, one clock wide |
| cnt_pin | input | 2 | External count pins, one per channel |
| gate_pin | input | 2 | External gate inputs, one per channel |
| ack | input | 2 | Interrupt acknowledge, one per channel |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| flag | output | 2 | Overflow flags |

## Verification
The hardest situation to reach is a collision in a single cycle. In one case a register write and an increment, or a write and an overflow, land on the same clock edge. In the other, an external pin glitch falls entirely between two ticks. The bench holds `tick` high in the same cycle as its write strobe to force the collisions. For the glitch, it drives `cnt_pin` low and back high while `tick` is low. Mode 10 and the 13-bit mode are swept over a grid of start values, reload values and step counts. Their expected values come from closed-form arithmetic.

// File: rtl/twin_timer.sv
module twin_timer #(
  parameter int PRE_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] cnt_pin,
  input  logic [1:0] gate_pin,
  input  logic [1:0] ack,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [1:0] flag
);
  logic [7:0]      mode_q;
  logic [1:0]      run_q, samp_q, inc, set;
  logic [1:0][7:0] lo_q, hi_q, lo_n, hi_n;
  logic            split_inc;

  assign split_inc = tick && run_q[1] && (mode_q[1:0] == 2'b11);

  always_comb begin
    for (int c = 0; c < 2; c++)
      inc[c] = tick && run_q[c] && (!mode_q[4*c+3] || gate_pin[c]) &&
               (mode_q[4*c+2] ? (samp_q[c] && !cnt_pin[c]) : 1'b1);
  end

  always_comb begin
    lo_n = lo_q;
    hi_n = hi_q;
    set  = '0;
    for (int c = 0; c < 2; c++) begin
      unique case (mode_q[4*c +: 2])
        2'b00: if (inc[c]) begin
          lo_n[c][PRE_W-1:0] = lo_q[c][PRE_W-1:0] + PRE_W'(1);
          if (&lo_q[c][PRE_W-1:0]) begin
            hi_n[c] = hi_q[c] + 8'd1;
            set[c]  = &hi_q[c];
          end
        end
        2'b01: if (inc[c]) begin
          {hi_n[c], lo_n[c]} = {hi_q[c], lo_q[c]} + 16'd1;
          set[c] = &{hi_q[c], lo_q[c]};
        end
        2'b10: if (inc[c]) begin
          if (&lo_q[c]) begin
            lo_n[c] = hi_q[c];
            set[c]  = 1'b1;
          end else begin
            lo_n[c] = lo_q[c] + 8'd1;
          end
        end
        default: if (c == 0 && inc[0]) begin
          lo_n[0] = lo_q[0] + 8'd1;
          set[0]  = &lo_q[0];
        end
      endcase
    end
    if (split_inc) begin
      hi_n[0] = hi_q[0] + 8'd1;
      set[1]  = set[1] | (&hi_q[0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
      samp_q <= '0;
      flag   <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      if (tick) samp_q <= cnt_pin;
      lo_q <= lo_n;
      hi_q <= hi_n;
      for (int c = 0; c < 2; c++) begin
        if (set[c])      flag[c] <= 1'b1;
        else if (ack[c]) flag[c] <= 1'b0;
      end
      if (wr_en) begin
        case (addr)
          3'd0: mode_q <= wdata;
          3'd1: begin
            run_q <= wdata[1:0];
            flag  <= wdata[3:2];
          end
          3'd2: lo_q[0] <= wdata;
          3'd3: hi_q[0] <= wdata;
          3'd4: lo_q[1] <= wdata;
          3'd5: hi_q[1] <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rdata = mode_q;
      3'd1:    rdata = {4'b0000, flag, run_q};
      3'd2:    rdata = lo_q[0];
      3'd3:    rdata = hi_q[0];
      3'd4:    rdata = lo_q[1];
      3'd5:    rdata = hi_q[1];
      default: rdata = 8'h00;
    endcase
  end
endmodule

module tt_check (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic            wr_en,
  input logic [1:0]      ack,
  input logic [7:0]      mode_q,
  input logic [1:0]      run_q,
  input logic [1:0]      flag,
  input logic [1:0][7:0] lo_q,
  input logic [1:0][7:0] hi_q
);
  assert_no_tick_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> ($stable(lo_q) && $stable(hi_q)));

  assert_run_off_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q[0] && !wr_en) |=> $stable(lo_q[0]));

  assert_flag_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag[0]) |-> ($past(wr_en) || $past(tick)));

  assert_ack_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[0] && flag[0] && !tick && !wr_en) |=> !flag[0]);

  assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && tick && run_q[0] && mode_q[3:0] == 4'b0010 && lo_q[0] == 8'hFF)
      |=> (lo_q[0] == $past(hi_q[0]) && flag[0]));

  assert_split_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[5:4] == 2'b11 && !wr_en) |=> ($stable(lo_q[1]) && $stable(hi_q[1])));
endmodule

bind twin_timer tt_check u_chk (.*);

// File: tb/tb_twin_timer.sv
`timescale 1ns/1ps
module tb_twin_timer;
  logic       clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [1:0] cnt_pin = 0, gate_pin = 0, ack = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [1:0] flag;
  int total = 0, fails = 0;

  twin_timer dut (.clk(clk), .rst_n(rst_n), .tick(tick), .cnt_pin(cnt_pin),
    .gate_pin(gate_pin), .ack(ack), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .flag(flag));

  always #2 clk = ~clk;

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic step(input int n);
    if (n > 0) begin
      @(negedge clk); tick = 1;
      repeat (n) @(negedge clk);
      tick = 0;
    end
  endtask

  task automatic tick_pin(input logic p);
    @(negedge clk); cnt_pin[0] = p; tick = 1;
    @(negedge clk); tick = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, h, c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) begin rd(3'(a), v); chk("R1 reset reg", v, 0); end
    chk("R1 reset flag", flag, 0);

    // R14 register map readback
    wr(0, 8'hA5); rd(0, v); chk("R14 mode byte", v, 8'hA5);
    wr(0, 8'h00);
    for (int a = 2; a < 6; a++) begin wr(3'(a), 8'(8'h30 + a)); end
    for (int a = 2; a < 6; a++) begin rd(3'(a), v); chk("R14 count bytes", v, 8'h30 + a); end
    rd(6, v); chk("R14 addr6", v, 0); rd(7, v); chk("R14 addr7", v, 0);
    wr(1, 8'h0C); rd(1, v); chk("R14 ctrl flags", v, 8'h0C); chk("R4 flag write", flag, 2'b11);
    wr(1, 8'h00); chk("R4 flag clear", flag, 0);

    // R2/R3 16-bit sweep on both channels
    begin
      int st[4] = '{16'hFFF0, 16'h00FF, 16'h1234, 16'hFFFE};
      int ks[3] = '{5, 20, 1};
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 3; j++)
          for (int ch = 0; ch < 2; ch++) begin
            int n;
            wr(1, 0); wr(0, 8'h11);
            wr(3'(2+2*ch), 8'(st[i])); wr(3'(3+2*ch), 8'(st[i] >> 8));
            wr(1, 8'(1 << ch));
            step(ks[j]);
            n = st[i] + ks[j];
            rd(3'(2+2*ch), v); rd(3'(3+2*ch), h);
            chk("R3 16-bit count", {h, v}, n & 16'hFFFF);
            chk("R3 16-bit flag", flag[ch], n > 16'hFFFF);
            chk("R2 other channel flag", flag[1-ch], 0);
          end
    end

    // R4 flag sticky, counting continues; R5 ack
    wr(1, 0); wr(0, 8'h01); wr(2, 8'hFF); wr(3, 8'hFF); wr(1, 8'h01);
    step(1); chk("R3 wrap flag", flag[0], 1);
    step(5); rd(2, v); chk("R4 count continues", v, 5); chk("R4 flag sticky", flag[0], 1);
    wr(1, 8'h09); chk("R4 sw clear flag0 only", flag, 2'b10);
    @(negedge clk); ack = 2'b01; @(negedge clk); ack = 0;
    chk("R5 ack other flag untouched", flag, 2'b10);
    @(negedge clk); ack = 2'b10; @(negedge clk); ack = 0;
    chk("R5 ack clears flag1", flag, 2'b00);
    wr(1, 8'h05);
    @(negedge clk); ack = 2'b01; @(negedge clk); ack = 0;
    chk("R5 ack clears flag0", flag, 2'b00);

    // R6 13-bit mode
    begin
      int sh[4] = '{8'hFF, 8'h12, 8'h00, 8'hFE};
      int sl[4] = '{8'hFC, 8'hA7, 8'h1F, 8'hE5};
      int ks[4] = '{4, 40, 1, 70};
      for (int i = 0; i < 4; i++) begin
        int n;
        wr(1, 0); wr(0, 8'h00); wr(2, 8'(sl[i])); wr(3, 8'(sh[i])); wr(1, 8'h01);
        step(ks[i]);
        n = sh[i] * 32 + (sl[i] & 31) + ks[i];
        rd(2, v); rd(3, h);
        chk("R6 13-bit low", v, (sl[i] & 8'hE0) | (n & 31));
        chk("R6 13-bit high", h, (n >> 5) & 8'hFF);
        chk("R6 13-bit flag", flag[0], n >= 8192);
      end
    end

    // R7 auto-reload sweep
    begin
      int rl[4] = '{8'hF0, 8'hFE, 8'hFF, 8'h00};
      int sl[2] = '{8'hFA, 8'hFF};
      int ks[3] = '{3, 10, 300};
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 2; j++)
          for (int k = 0; k < 3; k++) begin
            int s, el, ef;
            wr(1, 0); wr(0, 8'h02); wr(2, 8'(sl[j])); wr(3, 8'(rl[i])); wr(1, 8'h01);
            step(ks[k]);
            s = 256 - sl[j];
            if (ks[k] < s) begin el = sl[j] + ks[k]; ef = 0; end
            else begin el = rl[i] + (ks[k] - s) % (256 - rl[i]); ef = 1; end
            rd(2, v); rd(3, h);
            chk("R7 reload low", v, el);
            chk("R7 reload high kept", h, rl[i]);
            chk("R7 reload flag", flag[0], ef);
          end
    end

    // R8 run and gate
    wr(1, 0); wr(0, 8'h09); wr(2, 0); wr(3, 0); wr(1, 8'h01);
    gate_pin[0] = 0; step(10); rd(2, v); chk("R8 gate low blocks", v, 0);
    gate_pin[0] = 1; step(10); rd(2, v); chk("R8 gate high counts", v, 10);
    wr(1, 0); step(5); rd(2, v); chk("R8 run off holds", v, 10);
    wr(0, 8'h01); gate_pin[0] = 0; wr(1, 8'h01); step(7); rd(2, v);
    chk("R8 gate bit 0 ignores pin", v, 17);

    // R9 edge counting, R10 glitch between ticks
    begin
      logic pat[8] = '{1, 0, 0, 1, 0, 1, 1, 0};
      logic prev = 1;
      int e = 0;
      wr(1, 0); wr(0, 8'h05); wr(2, 0); wr(3, 0); wr(1, 8'h01);
      tick_pin(1);
      for (int i = 0; i < 8; i++) begin
        tick_pin(pat[i]);
        if (prev && !pat[i]) e++;
        prev = pat[i];
      end
      rd(2, v); chk("R9 falling edges counted", v, e);
      tick_pin(1);
      @(negedge clk); cnt_pin[0] = 0; repeat (3) @(negedge clk); cnt_pin[0] = 1;
      tick_pin(1); tick_pin(1);
      rd(2, v); chk("R10 glitch ignored", v, e);
      tick_pin(0); rd(2, v); chk("R9 edge after gap", v, e + 1);
      cnt_pin = 0;
    end

    // R11 split, R12 channel 1 hold
    wr(1, 0); wr(0, 8'h33);
    wr(2, 8'hFE); wr(3, 8'hFD); wr(4, 8'h55); wr(5, 8'h66); wr(1, 8'h03);
    step(3);
    rd(2, v); chk("R11 split low", v, 8'h01);
    rd(3, h); chk("R11 split high", h, 8'h00);
    chk("R11 split flags", flag, 2'b11);
    rd(4, v); chk("R12 ch1 low held", v, 8'h55);
    rd(5, h); chk("R12 ch1 high held", h, 8'h66);
    wr(1, 8'h01); step(2);
    rd(2, v); chk("R11 low runs on run0", v, 8'h03);
    rd(3, h); chk("R11 high stops with run1", h, 8'h00);

    // R13 write priority
    wr(1, 0); wr(0, 8'h01); wr(2, 8'h10); wr(3, 0); wr(1, 8'h01);
    @(negedge clk); tick = 1; wr_en = 1; addr = 2; wdata = 8'h80;
    @(negedge clk); wr_en = 0; tick = 0;
    rd(2, v); chk("R13 write beats increment", v, 8'h80);
    rd(3, h); chk("R13 high untouched", h, 0);
    wr(1, 0); wr(2, 8'hFF); wr(3, 8'hFF); wr(1, 8'h01);
    @(negedge clk); tick = 1; wr_en = 1; addr = 1; wdata = 8'h01;
    @(negedge clk); wr_en = 0; tick = 0;
    chk("R13 flag write beats set", flag[0], 0);
    rd(2, v); rd(3, h); chk("R13 count still wrapped", {h, v}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end
endmodule